// File: doc/BRIEF.md
# Byte-Lane Load/Store Formatter

This block sits between a 32-bit register datapath and a 32-bit little-endian data bus and shapes data for word and byte transfers. On the load side it takes the word read from the bus, the two low address bits and a byte/word select, and it returns the value to be written into the register file. On the store side it takes the register value and returns the bus write word together with four byte-enable strobes.

A byte store copies the low byte of the source into every lane of the write word. The strobes then select the lane that memory actually updates. A byte load picks one lane using the low address bits and fills the upper bits of the result with zeros. Word transfers pass through unchanged. A word access whose low address bits are not zero is reported on a misalign flag. The data still pass through, because the result of an unaligned word transfer is left undefined.

All outputs are registered in one stage by default, so they follow the inputs by one clock. An active-low asynchronous reset clears them. A parameter removes the stage and makes the block purely combinational.

Top module: `lane_steer`

## Requirements
- R1: On a byte load, the low address bits choose the source lane: 0 gives bus bits 7:0, 1 gives 15:8, 2 gives 23:16 and 3 gives 31:24. The chosen byte appears in bits 7:0 of the load result.
- R2: On a byte load, bits 31:8 of the load result are zero.
- R3: On a byte store, the write word holds the low 8 bits of the source in all four lanes.
- R4: On a byte store, exactly one strobe is high. Its bit index equals the low address bits, and strobe bit k enables bus bits 8k+7:8k.
- R5: On a word store, all four strobes are high and the write word equals the source word.
- R6: On a word load, the load result equals the bus read word for every value of the low address bits.
- R7: The misalign flag is high only for an active word access (load or store) whose low address bits are not 0. Byte accesses and idle cycles never raise it, and the data still pass through unchanged.
- R8: All strobes are zero when no access is active and during loads.
- R9: With the default configuration, every output reflects the inputs sampled at the previous rising clock edge, and all outputs are zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is active this cycle |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_byte_i | input | 1 | 1 = byte transfer, 0 = word transfer |
| addr_lo_i | input | 2 | Low address bits (byte offset within the word) |
| rd_data_i | input | 32 | Word read from the bus |
| st_data_i | input | 32 | Register value to be stored |
| ld_data_o | output | 32 | Formatted value for the register file |
| wr_data_o | output | 32 | Formatted bus write word |
| byte_en_o | output | 4 | Byte-enable strobes, bit k covers bus bits 8k+7:8k |
| misalign_o | output | 1 | Misaligned word access |

## Verification
On every cycle the assertions check four properties of the outputs:
- Byte-load results carry zeros above bit 7, and word loads pass the bus word through.
- The four lanes of a byte-store write word are identical.
- The strobe pattern is one-hot for byte stores, all ones for word stores and zero otherwise.
- The misalign flag follows the access of the previous cycle.

Only the bench's exhaustive sweep shows two further facts:
- Each address offset selects the right lane on loads and the right strobe bit on stores.
- Reset clears the outputs.

The sweep covers every combination of valid, direction, size and offset, each with several data patterns.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int LANE_W = 8;

  typedef enum logic {
    XFER_WORD = 1'b0,
    XFER_BYTE = 1'b1
  } xfer_size_e;
endpackage

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_steer_pkg::*;
#(
  parameter  int DATA_W    = 32,
  localparam int NUM_LANES = DATA_W / LANE_W,
  localparam int OFS_W     = $clog2(NUM_LANES)
) (
  input  logic [DATA_W-1:0] bus_word_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  xfer_size_e        size_i,
  output logic [DATA_W-1:0] reg_word_o
);
  logic [NUM_LANES-1:0][LANE_W-1:0] lanes;
  logic [LANE_W-1:0]                picked;

  assign lanes = bus_word_i;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (ofs_i == OFS_W'(i)) picked = lanes[i];
    end
  end

  assign reg_word_o = (size_i == XFER_BYTE) ? {{(DATA_W-LANE_W){1'b0}}, picked}
                                            : bus_word_i;
endmodule

// File: rtl/lane_store_replicate.sv
module lane_store_replicate
  import lane_steer_pkg::*;
#(
  parameter  int DATA_W    = 32,
  localparam int NUM_LANES = DATA_W / LANE_W,
  localparam int OFS_W     = $clog2(NUM_LANES)
) (
  input  logic [DATA_W-1:0]    src_word_i,
  input  logic [OFS_W-1:0]     ofs_i,
  input  xfer_size_e           size_i,
  input  logic                 store_i,
  output logic [DATA_W-1:0]    bus_word_o,
  output logic [NUM_LANES-1:0] strobe_o
);
  assign bus_word_o = (size_i == XFER_BYTE) ? {NUM_LANES{src_word_i[LANE_W-1:0]}}
                                            : src_word_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign strobe_o[g] = store_i & ((size_i == XFER_WORD) | (ofs_i == OFS_W'(g)));
  end
endmodule

// File: rtl/lane_align_check.sv
module lane_align_check
  import lane_steer_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             valid_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  xfer_size_e       size_i,
  output logic             misalign_o
);
  assign misalign_o = valid_i & (size_i == XFER_WORD) & (ofs_i != '0);
endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_steer_pkg::*;
#(
  parameter  int DATA_W    = 32,
  parameter  bit REG_OUT   = 1'b1,
  localparam int NUM_LANES = DATA_W / LANE_W,
  localparam int OFS_W     = $clog2(NUM_LANES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic                 acc_byte_i,
  input  logic [OFS_W-1:0]     addr_lo_i,
  input  logic [DATA_W-1:0]    rd_data_i,
  input  logic [DATA_W-1:0]    st_data_i,
  output logic [DATA_W-1:0]    ld_data_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic [NUM_LANES-1:0] byte_en_o,
  output logic                 misalign_o
);
  localparam int OUT_W = 2*DATA_W + NUM_LANES + 1;

  xfer_size_e           size;
  logic [DATA_W-1:0]    ld_d, wr_d;
  logic [NUM_LANES-1:0] be_d;
  logic                 mis_d;

  assign size = acc_byte_i ? XFER_BYTE : XFER_WORD;

  lane_load_extract #(.DATA_W(DATA_W)) u_load (
    .bus_word_i (rd_data_i),
    .ofs_i      (addr_lo_i),
    .size_i     (size),
    .reg_word_o (ld_d)
  );

  lane_store_replicate #(.DATA_W(DATA_W)) u_store (
    .src_word_i (st_data_i),
    .ofs_i      (addr_lo_i),
    .size_i     (size),
    .store_i    (acc_valid_i & acc_write_i),
    .bus_word_o (wr_d),
    .strobe_o   (be_d)
  );

  lane_align_check #(.OFS_W(OFS_W)) u_align (
    .valid_i    (acc_valid_i),
    .ofs_i      (addr_lo_i),
    .size_i     (size),
    .misalign_o (mis_d)
  );

  lane_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ld_d, wr_d, be_d, mis_d}),
    .q_o    ({ld_data_o, wr_data_o, byte_en_o, misalign_o})
  );
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic                  acc_write_i,
  input logic                  acc_byte_i,
  input logic [1:0]            addr_lo_i,
  input logic [DATA_W-1:0]     rd_data_i,
  input logic [DATA_W-1:0]     st_data_i,
  input logic [DATA_W-1:0]     ld_data_o,
  input logic [DATA_W-1:0]     wr_data_o,
  input logic [DATA_W/8-1:0]   byte_en_o,
  input logic                  misalign_o
);
  // Set after the first edge out of reset so $past never reads pre-reset inputs
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  if (REG_OUT) begin : g_chk
    assert_byte_zero_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(acc_byte_i) |-> ld_data_o[DATA_W-1:8] == '0);

    assert_word_load_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && !$past(acc_byte_i) |-> ld_data_o == $past(rd_data_i));

    assert_byte_store_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(acc_byte_i) |-> wr_data_o == {(DATA_W/8){wr_data_o[7:0]}});

    assert_byte_strobe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(acc_valid_i && acc_write_i && acc_byte_i) |-> $countones(byte_en_o) == 1);

    assert_word_strobe_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(acc_valid_i && acc_write_i && !acc_byte_i) |-> &byte_en_o);

    assert_idle_strobe_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(!(acc_valid_i && acc_write_i)) |-> byte_en_o == '0);

    assert_misalign_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> misalign_o == $past(acc_valid_i && !acc_byte_i && addr_lo_i != 2'd0));
  end
endmodule

bind lane_steer lane_steer_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_lane_steer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_byte_i  (acc_byte_i),
  .addr_lo_i   (addr_lo_i),
  .rd_data_i   (rd_data_i),
  .st_data_i   (st_data_i),
  .ld_data_o   (ld_data_o),
  .wr_data_o   (wr_data_o),
  .byte_en_o   (byte_en_o),
  .misalign_o  (misalign_o)
);

// File: tb/lane_steer_bench.sv
module lane_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, bsel = 1'b0;
  logic [1:0]  alo = '0;
  logic [31:0] rd = '0, st = '0;
  logic [31:0] ld_q, wr_q;
  logic [3:0]  be_q;
  logic        mis_q;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lane_steer u_lane_steer (
    .clk_i (clk), .rst_ni (rst_n),
    .acc_valid_i (valid), .acc_write_i (write), .acc_byte_i (bsel),
    .addr_lo_i (alo), .rd_data_i (rd), .st_data_i (st),
    .ld_data_o (ld_q), .wr_data_o (wr_q), .byte_en_o (be_q), .misalign_o (mis_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] e_ld, e_wr;
    logic [3:0]  e_be;
    logic        e_mis;
    lfsr = 32'hACE1_2357;
    // Reset state (R9)
    valid = 1'b1; write = 1'b1; rd = 32'hFFFF_FFFF; st = 32'hFFFF_FFFF; alo = 2'd1;
    repeat (3) @(negedge clk);
    chk("R9 reset ld", ld_q, 32'h0);
    chk("R9 reset wr", wr_q, 32'h0);
    chk("R9 reset be", {28'h0, be_q}, 32'h0);
    chk("R9 reset mis", {31'h0, mis_q}, 32'h0);
    rst_n = 1'b1;

    for (int pat = 0; pat < 8; pat++) begin
      for (int combo = 0; combo < 32; combo++) begin
        @(negedge clk);
        valid = combo[4]; write = combo[3]; bsel = combo[2]; alo = combo[1:0];
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        rd = (pat == 0) ? 32'h4433_2211 : lfsr;
        st = (pat == 0) ? 32'hDEAD_BEEF : ~{lfsr[15:0], lfsr[31:16]};
        e_ld  = bsel ? ((rd >> (8 * alo)) & 32'hFF) : rd;
        e_wr  = bsel ? {4{st[7:0]}} : st;
        e_be  = (valid && write) ? (bsel ? (4'b0001 << alo) : 4'hF) : 4'h0;
        e_mis = valid && !bsel && (alo != 2'd0);
        @(posedge clk);
        @(negedge clk);  // one registered stage (R9)
        chk(bsel ? "R1 R2 byte load" : "R6 word load", ld_q, e_ld);
        chk(bsel ? "R3 byte store data" : "R5 word store data", wr_q, e_wr);
        chk(!(valid && write) ? "R8 strobes idle/load" : (bsel ? "R4 byte strobe" : "R5 word strobe"),
            {28'h0, be_q}, {28'h0, e_be});
        chk("R7 misalign", {31'h0, mis_q}, {31'h0, e_mis});
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule